// File: doc/BRIEF.md
# Multi-speed data-strobe serializing transmitter

This block turns parallel words from a link-layer interface into a data-strobe encoded serial pair. It runs entirely on one fast bit clock. A free-running three-bit phase counter divides that clock by eight and marks one cycle in eight as the system-rate tick. At each tick the block samples the transmit-active flag. If the flag is high, it also captures one parallel word and pulses a word-accept strobe.

The word width and the bit rate change together with a two-bit speed code. The lowest speed sends 2 bits per word, one every 4 fast clocks. The middle speed sends 4 bits per word, one every 2 fast clocks. The highest speed sends 8 bits per word, one on every fast clock. In every case a word takes exactly one system period on the line.

The speed code is latched when a packet begins. A packet ends when transmit-active is seen low at a tick. While idle, both line outputs sit at 0.

Top module: `ds_serializer`

## Requirements
- R1: The speed code selects the word width. Code 0 takes `lane[1:0]`, code 1 takes `lane[3:0]`, and codes 2 and 3 take `lane[7:0]`. Lane bits above the selected width have no effect on the line.
- R2: A word is captured only at a system tick, which comes once every 8 fast clocks. When `tx_active` is high at that edge, `word_take` is high for exactly the one following cycle. Successive accepts within a packet are therefore 8 clocks apart.
- R3: Each serial bit is held on the line for a fixed number of fast clocks: 4 clocks at code 0, 2 clocks at code 1, and 1 clock at codes 2 and 3.
- R4: The bits of each word go out most-significant first. `ds_data` carries the bit value itself.
- R5: At each new bit, `ds_strobe` inverts if the new bit equals the previous bit. Otherwise `ds_strobe` keeps its value. Exactly one of the two lines changes per bit.
- R6: At packet start the previous bit is taken as 0 and the strobe starts from 0. So a first bit of 0 gives strobe 1, and a first bit of 1 gives strobe 0.
- R7: A tick with `tx_active` low forces `ds_data` and `ds_strobe` to 0 and produces no `word_take`.
- R8: The speed code is sampled only at the first accept of a packet. Changing it later in the packet has no effect until the next packet.
- R9: After reset, `ds_data`, `ds_strobe` and `word_take` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, 8x the system rate |
| rst_n | input | 1 | Active-low synchronous reset |
| speed | input | 2 | Speed code: 0 low, 1 middle, 2/3 high |
| tx_active | input | 1 | High while a packet is being sent |
| lane | input | 8 | Parallel data bits from the link layer |
| ds_data | output | 1 | Encoded serial data line |
| ds_strobe | output | 1 | Encoded serial strobe line |
| word_take | output | 1 | One-cycle pulse after a word is captured |

## Verification
The bench recovers bits from the line pair by watching for changes in the XOR of data and strobe. It measures the number of fast clocks between changes, so a wrong divider or bit order shows up as a bit-period or value mismatch. It checks the strobe rule on every bit and checks the first bit of every packet separately. A design that kept the previous bit across packets would give the wrong first strobe.

The bench fills unused lane bits with junk to expose a design that ignores the selected width. It changes the speed code after a packet's first accept to catch a design that follows the live code. It checks the gap between accepts and the return to 0,0 after a packet. A design that failed to clear the lines at the idle tick would leave stale levels on the lines.

// File: rtl/ds_serializer.sv
module ds_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed,
  input  logic       tx_active,
  input  logic [7:0] lane,
  output logic       ds_data,
  output logic       ds_strobe,
  output logic       word_take
);

  logic [2:0] ph;
  logic       run;
  logic [1:0] spd;
  logic [7:0] sh;
  logic       emit_q;

  wire       tick   = (ph == 3'd7);
  wire       load   = tick & tx_active;
  wire [1:0] sp_now = (load && !run) ? speed : spd;
  wire [1:0] lv     = sp_now[1] ? 2'd2 : sp_now;
  wire [2:0] mask   = (lv == 2'd2) ? 3'd0 : (lv == 2'd1) ? 3'd1 : 3'd3;
  wire       bnd    = (ph & mask) == mask;
  wire [7:0] packed_w = (lv == 2'd2) ? lane :
                        (lv == 2'd1) ? {lane[3:0], 4'b0} : {lane[1:0], 6'b0};
  wire [7:0] src    = tick ? packed_w : sh;
  wire       bit_o  = src[7];
  wire       run_n  = tick ? tx_active : run;
  wire       emit   = run_n & bnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      run       <= 1'b0;
      spd       <= '0;
      sh        <= '0;
      ds_data   <= 1'b0;
      ds_strobe <= 1'b0;
      word_take <= 1'b0;
      emit_q    <= 1'b0;
    end else begin
      ph        <= ph + 3'd1;
      word_take <= load;
      emit_q    <= emit;
      if (tick) run <= tx_active;
      if (load && !run) spd <= speed;
      if (tick && !tx_active) begin
        ds_data   <= 1'b0;
        ds_strobe <= 1'b0;
      end else if (emit) begin
        ds_data   <= bit_o;
        ds_strobe <= (bit_o == ds_data) ? ~ds_strobe : ds_strobe;
        sh        <= src << 1;
      end
    end
  end

  p_take_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> !word_take);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tx_active) |=> (!ds_data && !ds_strobe && !word_take));

  p_one_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emit_q |-> ($countones({ds_data ^ $past(ds_data), ds_strobe ^ $past(ds_strobe)}) == 1));

  p_hold_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !emit_q) |-> $stable({ds_data, ds_strobe}));

  p_speed_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(spd));

endmodule

// File: tb/test_ds_serializer.sv
module test_ds_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed = 2'd0;
  logic       tx_active = 1'b0;
  logic [7:0] lane = 8'd0;
  logic       ds_data, ds_strobe, word_take;

  always #10 clk = ~clk;

  ds_serializer i_ds_serializer (
    .clk(clk), .rst_n(rst_n), .speed(speed), .tx_active(tx_active),
    .lane(lane), .ds_data(ds_data), .ds_strobe(ds_strobe), .word_take(word_take)
  );

  typedef struct packed { logic b; int per; } item_t;
  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  logic [7:0] pk [0:15];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  logic lastpar = 1'b0, pd = 1'b0, ps = 1'b0;
  int cyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic par;
      item_t it;
      par = ds_data ^ ds_strobe;
      cyc++;
      if (par != lastpar) begin
        if (exp_q.size() > 0) begin
          it = exp_q.pop_front();
          chk(ds_data == it.b, "R4 bit value", ds_data, it.b);
          if (it.per == 0) begin
            chk(ds_strobe == ~it.b, "R6 first strobe", ds_strobe, ~it.b);
          end else begin
            chk(cyc == it.per, "R3 bit period", cyc, it.per);
            chk(ds_strobe == ((ds_data == pd) ? ~ps : ps), "R5 strobe rule",
                ds_strobe, (ds_data == pd) ? ~ps : ps);
          end
          pd = ds_data;
          ps = ds_strobe;
        end
        cyc = 0;
      end
      lastpar = par;
    end
  end

  task automatic send_pkt(input logic [1:0] sp, input int n, input logic [1:0] sp_mid);
    int lv, w, per, g;
    wait (exp_q.size() == 0);
    repeat (20) @(negedge clk);
    lv  = sp[1] ? 2 : int'(sp);
    w   = 2 << lv;
    per = 4 >> lv;
    for (int i = 0; i < n; i++)
      for (int b = w - 1; b >= 0; b--)
        exp_q.push_back('{b: pk[i][b], per: (i == 0 && b == w - 1) ? 0 : per});
    speed = sp;
    lane = pk[0];
    tx_active = 1'b1;
    for (int i = 0; i < n; i++) begin
      g = 0;
      do begin @(negedge clk); g++; end while (!word_take && g < 40);
      chk(word_take, "R2 word accepted", word_take, 1);
      if (i > 0) chk(g == 8, "R2 accept spacing", g, 8);
      if (i == 0) speed = sp_mid;
      if (i == n - 1) begin
        tx_active = 1'b0;
        lane = 8'h5a;
      end else begin
        lane = pk[i + 1];
      end
    end
    g = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (word_take) g++;
    end
    chk(g == 0, "R7 no accept while idle", g, 0);
    chk(!ds_data && !ds_strobe, "R7 idle lines low", {ds_data, ds_strobe}, 0);
    chk(exp_q.size() == 0, "R4 all bits seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ds_data && !ds_strobe && !word_take, "R9 reset state",
        {ds_data, ds_strobe, word_take}, 0);

    // R1 low speed with junk upper bits; R8 mid change ignored
    pk[0] = 8'hfe; pk[1] = 8'h01; pk[2] = 8'hab; pk[3] = 8'h7c; pk[4] = 8'h33;
    send_pkt(2'd0, 5, 2'd2);
    // R1 middle speed, speed change to 0 ignored (R8)
    pk[0] = 8'hf0; pk[1] = 8'h2f; pk[2] = 8'h95; pk[3] = 8'h3a;
    send_pkt(2'd1, 4, 2'd0);
    // R1 high speed, runs of equal bits for R5
    pk[0] = 8'h00; pk[1] = 8'hff; pk[2] = 8'haa; pk[3] = 8'h96; pk[4] = 8'h0f;
    send_pkt(2'd2, 5, 2'd1);
    // code 3 behaves as high speed, first bit 1 for R6
    pk[0] = 8'hc3; pk[1] = 8'h55; pk[2] = 8'h81;
    send_pkt(2'd3, 3, 2'd0);
    // low speed again, single word
    pk[0] = 8'h02;
    send_pkt(2'd0, 1, 2'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule